// File: doc/BRIEF.md
# Block Burst Spacing Timer

This block sets the gap between successive burst blocks of one DMA channel. Each time the channel finishes a block, the timer loads a 16-bit gap value and counts it down. The countdown is clocked through a prescaler chosen by a 2-bit code. When the gap has run out, the timer raises a ready flag, and the channel may then ask for the bus again. This repeats for every block until the channel stops.

The channel logic holds `chan_active_i` high for a whole run. It pulses `block_done_i` for one cycle at the end of each block, and it requests the bus only while `ready_o` is high. The gap value and the prescaler code are taken at the block-done pulse. Later changes to them do not alter a countdown that is already running.

Top module: `blk_gap_timer`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, `ready_o` is 0.
- R2: When `chan_active_i` is 0, `ready_o` is 0 on the next cycle and any countdown in progress is dropped. A `block_done_i` pulse while inactive starts nothing.
- R3: When the channel is active and no gap is being counted, `ready_o` is 1 from the cycle after activation. The first block of a run is therefore never delayed.
- R4: A `block_done_i` pulse sampled on an active clock edge, with gap value N > 0, drives `ready_o` to 0 after that edge. `ready_o` returns to 1 exactly N·D clock edges later, where D is the divisor of R5.
- R5: The prescaler code maps to divisors as follows: code 0 gives D = 1, code 1 gives 4, code 2 gives 16 and code 3 gives 64.
- R6: A gap value of 0 keeps `ready_o` at 1 on the cycle right after the block-done edge.
- R7: The prescaler phase is cleared by every block-done pulse, so each gap measures exactly N·D cycles whatever the earlier phase was.
- R8: A block-done pulse that arrives while a gap is being counted restarts the countdown from the newly sampled value.
- R9: Once `ready_o` is 1, it stays at 1 until the next block-done pulse or until the channel goes inactive.
- R10: Changes to `interval_i` and `prescale_i` after the block-done edge do not affect the gap that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_active_i | input | 1 | Channel is running a transfer sequence |
| block_done_i | input | 1 | One-cycle pulse at the end of a burst block |
| interval_i | input | 16 | Gap length in prescaled ticks |
| prescale_i | input | 2 | Prescaler code (divide by 1/4/16/64) |
| ready_o | output | 1 | Next block may request the bus (registered) |

## Verification
The bench builds the block with its defaults: a 16-bit interval and a 2-bit prescaler code. This brings every divisor, up to divide-by-64, within reach, and a gap of 300 ticks at divide-by-64 runs for 19,200 cycles. A restart that arrives in mid-phase under divide-by-16 shows whether the prescaler phase is cleared. Gaps of zero and one cover the shortest countdowns.

// File: rtl/gap_timer_pkg.sv
package gap_timer_pkg;
  // each prescaler code step multiplies the divisor by 2**PRESC_STEP
  localparam int PRESC_STEP = 2;

  function automatic int presc_cnt_width(input int code_w, input int step);
    return step * ((1 << code_w) - 1);
  endfunction
endpackage

// File: rtl/gap_prescaler.sv
module gap_prescaler
  import gap_timer_pkg::*;
#(
  parameter int CODE_W = 2,
  parameter int STEP   = PRESC_STEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int PC_W = (presc_cnt_width(CODE_W, STEP) > 0) ? presc_cnt_width(CODE_W, STEP) : 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_val;

  // terminal count = divisor - 1, divisor = 2**(STEP*code)
  always_comb begin
    last_val = '0;
    for (int b = 0; b < PC_W; b++) begin
      if (b < STEP * int'(code_i)) last_val[b] = 1'b1;
    end
  end

  assign tick_o = run_i && (pc_q == last_val);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pc_q <= '0;
    end else if (run_i) begin
      pc_q <= (pc_q == last_val) ? '0 : pc_q + 1'b1;
    end
  end

  // R7
  phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (pc_q == '0));

  // R5
  pc_range_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q <= last_val);
endmodule

// File: rtl/gap_countdown.sv
module gap_countdown #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [IW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          counting_o,
  output logic          expire_o
);
  logic [IW-1:0] cnt_q;
  logic          run_q;

  assign counting_o = run_q;
  assign expire_o   = run_q && tick_i && (cnt_q == IW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= (load_val_i != '0);
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == IW'(1)) run_q <= 1'b0;
    end
  end

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clear_i && load_val_i != '0) |=> (run_q && cnt_q == $past(load_val_i)));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/blk_gap_timer.sv
module blk_gap_timer
  import gap_timer_pkg::*;
#(
  parameter int IW     = 16,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_active_i,
  input  logic              block_done_i,
  input  logic [IW-1:0]     interval_i,
  input  logic [CODE_W-1:0] prescale_i,
  output logic              ready_o
);
  logic              start;
  logic              drop;
  logic [CODE_W-1:0] code_q;
  logic              tick;
  logic              counting;
  logic              expire;
  logic              ready_q;

  assign start = chan_active_i && block_done_i;
  assign drop  = !chan_active_i;

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else if (start) code_q <= prescale_i;
  end

  gap_prescaler #(.CODE_W(CODE_W), .STEP(PRESC_STEP)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start || drop),
    .run_i   (counting),
    .code_i  (code_q),
    .tick_o  (tick)
  );

  gap_countdown #(.IW(IW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (drop),
    .load_i     (start),
    .load_val_i (interval_i),
    .tick_i     (tick),
    .counting_o (counting),
    .expire_o   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst || drop) begin
      ready_q <= 1'b0;
    end else if (start) begin
      ready_q <= (interval_i == '0);
    end else if (!counting || expire) begin
      ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  // R2
  inactive_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_active_i |=> !ready_o);

  // R4
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (start && interval_i != '0) |=> !ready_o);

  // R6
  zero_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (start && interval_i == '0) |=> ready_o);

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && chan_active_i && !block_done_i) |=> ready_o);
endmodule

// File: tb/tb_blk_gap_timer.sv
module tb_blk_gap_timer;
  localparam int IW = 16;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          chan_active_i;
  logic          block_done_i;
  logic [IW-1:0] interval_i;
  logic [CW-1:0] prescale_i;
  logic          ready_o;

  always #5 clk = ~clk;

  blk_gap_timer #(.IW(IW), .CODE_W(CW)) dut (
    .clk(clk), .rst(rst), .chan_active_i(chan_active_i), .block_done_i(block_done_i),
    .interval_i(interval_i), .prescale_i(prescale_i), .ready_o(ready_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    measuring = 1'b0;
  int    elapsed = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: counts edges from the block-done edge until ready is seen
  always @(negedge clk) begin
    if (measuring) begin
      if (ready_o) begin
        if (exp_q.size() > 0) begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(elapsed == e, t, "gap length in cycles", elapsed, e);
        end
        measuring = 1'b0;
      end else begin
        elapsed++;
      end
    end
  end

  // driver: one block-done pulse, expected gap N * 4**code (R5)
  task automatic block(input int n, input int code, input string req);
    @(negedge clk);
    interval_i   = IW'(n);
    prescale_i   = CW'(code);
    block_done_i = 1'b1;
    @(posedge clk);
    #1;
    block_done_i = 1'b0;
    interval_i   = 16'h00FF;      // R10: scrambled after sampling
    prescale_i   = ~CW'(code);
    exp_q.delete();
    tag_q.delete();
    exp_q.push_back(n * (1 << (2 * code)));
    tag_q.push_back(req);
    elapsed   = 0;
    measuring = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int guard = 0;
    while (measuring && guard < 30000) begin
      @(negedge clk);
      guard++;
    end
    #1;
    check(!measuring, req, "ready never returned", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; chan_active_i = 1'b0; block_done_i = 1'b0;
    interval_i = '0; prescale_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready_o == 1'b0, "R1", "ready in reset", ready_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ready_o == 1'b0, "R1", "ready after reset, inactive", ready_o, 0);
    chan_active_i = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b1, "R3", "ready before first block", ready_o, 1);

    block(5, 0, "R4");   wait_done("R4");
    block(0, 0, "R6");   wait_done("R6");
    block(1, 0, "R4");   wait_done("R4");
    block(3, 1, "R5");   wait_done("R5");
    block(2, 2, "R5");   wait_done("R5");
    block(1, 3, "R5");   wait_done("R5");
    block(300, 3, "R5"); wait_done("R5");
    block(6, 1, "R10");  wait_done("R10");

    repeat (20) @(negedge clk);
    check(ready_o == 1'b1, "R9", "ready held while idle", ready_o, 1);

    // restart mid-count, prescaler in mid-phase
    block(3, 2, "R8");
    repeat (7) @(negedge clk);
    check(ready_o == 1'b0, "R8", "ready low while counting", ready_o, 0);
    block(2, 2, "R7");   wait_done("R7");
    block(4, 0, "R8");
    repeat (2) @(negedge clk);
    block(4, 0, "R8");   wait_done("R8");

    // deactivate during a gap
    block(100, 0, "R2");
    repeat (3) @(negedge clk);
    #1;
    chan_active_i = 1'b0;
    measuring = 1'b0;
    exp_q.delete();
    tag_q.delete();
    @(negedge clk);
    check(ready_o == 1'b0, "R2", "ready after inactive", ready_o, 0);
    block_done_i = 1'b1;
    interval_i   = 16'd50;
    @(negedge clk);
    block_done_i = 1'b0;
    repeat (4) @(negedge clk);
    check(ready_o == 1'b0, "R2", "ready stays low while inactive", ready_o, 0);
    chan_active_i = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b1, "R2", "no stale countdown on reactivation", ready_o, 1);
    check(ready_o == 1'b1, "R3", "ready on new run", ready_o, 1);

    block(2, 1, "R9");   wait_done("R9");
    repeat (5) @(negedge clk);
    check(ready_o == 1'b1, "R9", "ready held after gap", ready_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule